// File: doc/BRIEF.md
# Synchronous FIFO Bus Master (single receive, single transmit channel)

This block is the master side of a synchronous slave FIFO bus that has one receive channel and one transmit channel. It runs on the clock that the slave supplies, at about 66.67 MHz or 100 MHz. The block watches two active-low status flags from the slave. One flag says the slave has room for a write. The other says the slave holds data for a read. The block moves words from a local transmit stream into the slave, and moves words from the slave onto a local receive stream.

Writes use an active-low write strobe. The bus carries the data and byte enables while the strobe is low. On the last word of a packet the block also pulls the send-immediate strobe low, and the byte enables of that word mark the valid bytes of a partial final word. Reads take two steps. The output-enable strobe goes low first, which hands the data bus to the slave. The read strobe follows one clock later. Output enable is released one clock after the read strobe. While output enable is high, the master owns the data and byte-enable buses; the pad tristate is driven from that strobe outside this block.

When both directions have work, the block alternates between read and write bursts. A read burst comes first after reset. Each burst is limited to `BURST_LEN` words. A word presented on a clock edge where the relevant flag is inactive is not counted. An uncounted write word is kept and offered again later. Uncounted read data is dropped.

Top module: `sync_fifo_master`

## Requirements
- R1: While reset is held, the output-enable, read, write and send-immediate strobes are all high (inactive), rx_valid is 0 and tx_ready is 0.
- R2: A write word is transferred only at a clock edge where the write strobe and the room flag are both low. Every transmit-stream word reaches the slave exactly once and in order, including when the room flag goes high in the middle of a burst. No write strobe is issued while the room flag stays high.
- R3: The send-immediate strobe is low only on the cycles that carry the word marked tx_last, and always together with the write strobe. The byte enables on each written word equal that word's tx_keep, where bit i enables byte i (data bits 8i+7..8i).
- R4: The output-enable strobe is low during the cycle before the read strobe falls, and it is still low during the cycle after the read strobe rises.
- R5: A read word is taken only at a clock edge where the read strobe and the data flag are both low. Each taken word appears on rx_data, with rx_valid high, in the following cycle. Data present at an edge where the flag is high is discarded. Words arrive in slave order with none lost or repeated.
- R6: The read and write strobes are never low in the same cycle, and the write strobe is low only while output enable is high.
- R7: When both directions are pending, bursts alternate between read and write, and after reset the read burst goes first.
- R8: A single read burst or write burst transfers at most BURST_LEN words (default 4). A read burst that has BURST_LEN words available transfers exactly BURST_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock supplied by the slave |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_tx_room_n | input | 1 | Low when the slave can accept a write word |
| bus_rx_avail_n | input | 1 | Low when the slave holds a word to read |
| bus_oe_n | output | 1 | Output enable; low hands the data and byte-enable buses to the slave |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_flush_n | output | 1 | Send-immediate strobe, low on the final word of a packet |
| bus_dout | output | DATA_W | Write data driven toward the slave |
| bus_be_out | output | DATA_W/8 | Byte enables driven with write data |
| bus_din | input | DATA_W | Read data from the slave |
| bus_be_in | input | DATA_W/8 | Byte enables from the slave with read data |
| tx_valid | input | 1 | Transmit stream word valid |
| tx_ready | output | 1 | Transmit stream word taken |
| tx_data | input | DATA_W | Transmit stream data |
| tx_keep | input | DATA_W/8 | Valid bytes of the transmit word |
| tx_last | input | 1 | Final word of a packet |
| rx_valid | output | 1 | Receive stream word valid, one cycle |
| rx_data | output | DATA_W | Receive stream data |
| rx_keep | output | DATA_W/8 | Byte enables that came with the received word |

## Verification
The first write packet runs with the room flag held low and a partial final word. It shows whether send-immediate and the byte enables sit on the correct word. A second packet toggles the room flag every third cycle, so a loss or duplicate in the retry path shows up as a wrong word order. The reads are tried once with the data flag held low, which checks the exact burst length, and once with the flag pulsed high, which separates discarded data from counted data. A final run keeps both directions pending at once, so the order of strobe starts shows the alternation and the read-first start.

// File: rtl/sync_fifo_master_pkg.sv
// Shared types for the synchronous FIFO bus master.
package sync_fifo_master_pkg;
    // Bus phases: idle, write burst, read turnaround, read burst, read release.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WRITE   = 3'd1,
        ST_RD_TURN = 3'd2,
        ST_READ    = 3'd3,
        ST_RD_HOLD = 3'd4
    } bus_phase_e;
endpackage

// File: rtl/sfm_arbiter.sv
// Phase sequencer: picks read or write bursts, alternating when both are
// pending, counts words per burst and sequences the read turnaround.
// Assumes wr_exit/accept inputs are qualified with the current phase.
module sfm_arbiter
    import sync_fifo_master_pkg::*;
#(
    parameter int BURST_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_pending,
    input  logic       rd_pending,
    input  logic       wr_exit,
    input  logic       wr_accept,
    input  logic       rd_accept,
    output bus_phase_e phase,
    output logic       burst_cap
);
    localparam int CW = $clog2(BURST_LEN + 1);

    bus_phase_e     phase_nxt;
    logic [CW-1:0]  word_cnt;
    logic           last_was_wr;

    assign burst_cap = (word_cnt == CW'(BURST_LEN - 1));

    // Next phase selection.
    always_comb begin
        phase_nxt = phase;
        case (phase)
            ST_IDLE: begin
                if (wr_pending && rd_pending)
                    phase_nxt = last_was_wr ? ST_RD_TURN : ST_WRITE;
                else if (rd_pending)
                    phase_nxt = ST_RD_TURN;
                else if (wr_pending)
                    phase_nxt = ST_WRITE;
            end
            ST_WRITE:   if (wr_exit) phase_nxt = ST_IDLE;
            ST_RD_TURN: phase_nxt = ST_READ;
            ST_READ:    if (!rd_accept || burst_cap) phase_nxt = ST_RD_HOLD;
            ST_RD_HOLD: phase_nxt = ST_IDLE;
            default:    phase_nxt = ST_IDLE;
        endcase
    end

    // Phase register, burst word counter and direction history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= ST_IDLE;
            word_cnt    <= '0;
            last_was_wr <= 1'b1;
        end else begin
            phase <= phase_nxt;
            if (phase == ST_IDLE)
                word_cnt <= '0;
            else if (wr_accept || rd_accept)
                word_cnt <= word_cnt + 1'b1;
            if (phase == ST_IDLE && phase_nxt == ST_WRITE)
                last_was_wr <= 1'b1;
            else if (phase == ST_IDLE && phase_nxt == ST_RD_TURN)
                last_was_wr <= 1'b0;
        end
    end
endmodule

// File: rtl/sfm_tx_stage.sv
// Write path: one holding register presented on the bus while the write
// strobe is low. A held word stays until the slave takes it (room flag low
// at the edge), so a word refused on a full slave is retried.
module sfm_tx_stage #(
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_write,
    input  logic              burst_cap,
    input  logic              room_n,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [BE_W-1:0]   tx_keep,
    input  logic              tx_last,
    output logic              tx_ready,
    output logic              hold_vld,
    output logic              wr_accept,
    output logic              wr_exit,
    output logic [DATA_W-1:0] bus_dout,
    output logic [BE_W-1:0]   bus_be_out,
    output logic              bus_wr_n,
    output logic              bus_flush_n
);
    logic hold_last;
    logic closing;
    logic take;

    assign wr_accept   = in_write && hold_vld && !room_n;
    assign closing     = wr_accept && (hold_last || burst_cap);
    assign take        = in_write && !closing && (!hold_vld || wr_accept);
    assign tx_ready    = take;
    assign wr_exit     = closing || (take && !tx_valid) || (in_write && hold_vld && room_n);
    assign bus_wr_n    = !(in_write && hold_vld);
    assign bus_flush_n = !(in_write && hold_vld && hold_last);

    // Holding register load and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld   <= 1'b0;
            hold_last  <= 1'b0;
            bus_dout   <= '0;
            bus_be_out <= '0;
        end else if (take && tx_valid) begin
            hold_vld   <= 1'b1;
            hold_last  <= tx_last;
            bus_dout   <= tx_data;
            bus_be_out <= tx_keep;
        end else if (wr_accept) begin
            hold_vld   <= 1'b0;
        end
    end
endmodule

// File: rtl/sfm_rx_stage.sv
// Read capture: registers a word the slave delivered on an accepted edge and
// presents it for one cycle on the receive stream. Sink never stalls.
module sfm_rx_stage #(
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_accept,
    input  logic [DATA_W-1:0] bus_din,
    input  logic [BE_W-1:0]   bus_be_in,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic [BE_W-1:0]   rx_keep
);
    // Capture of accepted read words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_keep  <= '0;
        end else begin
            rx_valid <= rd_accept;
            if (rd_accept) begin
                rx_data <= bus_din;
                rx_keep <= bus_be_in;
            end
        end
    end
endmodule

// File: rtl/sync_fifo_master.sv
// Master controller for a single-channel synchronous slave FIFO bus.
// Assumes clk is the slave-supplied bus clock and that the receive sink
// accepts every rx_valid word.
module sync_fifo_master
    import sync_fifo_master_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int BURST_LEN = 4,
    localparam int BE_W     = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_tx_room_n,
    input  logic              bus_rx_avail_n,
    output logic              bus_oe_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_flush_n,
    output logic [DATA_W-1:0] bus_dout,
    output logic [BE_W-1:0]   bus_be_out,
    input  logic [DATA_W-1:0] bus_din,
    input  logic [BE_W-1:0]   bus_be_in,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [BE_W-1:0]   tx_keep,
    input  logic              tx_last,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic [BE_W-1:0]   rx_keep
);
    bus_phase_e phase;
    logic       burst_cap;
    logic       hold_vld;
    logic       wr_accept;
    logic       wr_exit;
    logic       rd_accept;
    logic       wr_pending;

    assign wr_pending = (hold_vld || tx_valid) && !bus_tx_room_n;
    assign rd_accept  = (phase == ST_READ) && !bus_rx_avail_n;
    assign bus_rd_n   = (phase != ST_READ);
    assign bus_oe_n   = !(phase == ST_RD_TURN || phase == ST_READ || phase == ST_RD_HOLD);

    sfm_arbiter #(.BURST_LEN(BURST_LEN)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_pending (wr_pending),
        .rd_pending (!bus_rx_avail_n),
        .wr_exit    (wr_exit),
        .wr_accept  (wr_accept),
        .rd_accept  (rd_accept),
        .phase      (phase),
        .burst_cap  (burst_cap)
    );

    sfm_tx_stage #(.DATA_W(DATA_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_write    (phase == ST_WRITE),
        .burst_cap   (burst_cap),
        .room_n      (bus_tx_room_n),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data),
        .tx_keep     (tx_keep),
        .tx_last     (tx_last),
        .tx_ready    (tx_ready),
        .hold_vld    (hold_vld),
        .wr_accept   (wr_accept),
        .wr_exit     (wr_exit),
        .bus_dout    (bus_dout),
        .bus_be_out  (bus_be_out),
        .bus_wr_n    (bus_wr_n),
        .bus_flush_n (bus_flush_n)
    );

    sfm_rx_stage #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_accept (rd_accept),
        .bus_din   (bus_din),
        .bus_be_in (bus_be_in),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_keep   (rx_keep)
    );
endmodule

// File: rtl/sync_fifo_master_chk.sv
// Protocol checker for sync_fifo_master, attached by bind.
module sync_fifo_master_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_oe_n,
    input logic bus_rd_n,
    input logic bus_wr_n,
    input logic bus_flush_n,
    input logic bus_rx_avail_n,
    input logic rx_valid
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (bus_rd_n && bus_wr_n && bus_oe_n && bus_flush_n)); // R1
    AST_NO_STROBE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(!bus_rd_n && !bus_wr_n)); // R6
    AST_WRITE_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n) !bus_wr_n |-> bus_oe_n); // R6
    AST_OE_LEADS_READ: assert property (@(posedge clk) disable iff (!rst_n) $fell(bus_rd_n) |-> $past(!bus_oe_n)); // R4
    AST_OE_TRAILS_READ: assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_rd_n) |-> !bus_oe_n); // R4
    AST_FLUSH_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !bus_flush_n |-> !bus_wr_n); // R3
    AST_READ_DELIVERED: assert property (@(posedge clk) disable iff (!rst_n) (!bus_rd_n && !bus_rx_avail_n) |=> rx_valid); // R5
    AST_RX_ONLY_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> $past(!bus_rd_n && !bus_rx_avail_n)); // R5
endmodule

bind sync_fifo_master sync_fifo_master_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_oe_n       (bus_oe_n),
    .bus_rd_n       (bus_rd_n),
    .bus_wr_n       (bus_wr_n),
    .bus_flush_n    (bus_flush_n),
    .bus_rx_avail_n (bus_rx_avail_n),
    .rx_valid       (rx_valid)
);

// File: tb/sync_fifo_master_bench.sv
`timescale 1ns/1ps
// Directed bench: a behavioural slave, a transmit source and a receive log,
// with one task per scenario.
module sync_fifo_master_bench;
    localparam int DW  = 32;
    localparam int BEW = DW / 8;
    localparam int BL  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic           bus_tx_room_n, bus_rx_avail_n;
    logic           bus_oe_n, bus_rd_n, bus_wr_n, bus_flush_n;
    logic [DW-1:0]  bus_dout, bus_din;
    logic [BEW-1:0] bus_be_out, bus_be_in;
    logic           tx_valid, tx_ready, tx_last;
    logic [DW-1:0]  tx_data;
    logic [BEW-1:0] tx_keep;
    logic           rx_valid;
    logic [DW-1:0]  rx_data;
    logic [BEW-1:0] rx_keep;

    int n_chk = 0;
    int n_fail = 0;

    // Slave read source.
    logic [DW-1:0] src [0:63];
    logic [5:0]    src_len = 0, src_ptr;
    logic          avail_block = 1'b0;
    assign bus_rx_avail_n = avail_block || (src_ptr >= src_len);
    assign bus_din   = (!bus_oe_n) ? src[src_ptr] : '0;
    assign bus_be_in = '1;

    // Slave write side.
    logic           room_block = 1'b0;
    assign bus_tx_room_n = room_block;
    logic [DW-1:0]  wr_log [0:63];
    logic [BEW-1:0] wr_be  [0:63];
    logic           wr_fl  [0:63];
    logic [5:0]     wr_cnt;

    // Transmit stream source.
    logic [DW-1:0]  tx_vec [0:63];
    logic [5:0]     tx_len = 0, tx_idx;
    logic [BEW-1:0] last_keep = '1;
    assign tx_valid = tx_idx < tx_len;
    assign tx_data  = tx_vec[tx_idx];
    assign tx_last  = (tx_idx == tx_len - 1);
    assign tx_keep  = tx_last ? last_keep : '1;

    // Receive log and protocol monitor.
    logic [DW-1:0] rx_log [0:63];
    logic [5:0]    rx_cnt;
    int ovl_err, oe_err, rd_run, wr_run, max_rd_run, max_wr_run, ev_cnt;
    logic ev [0:63];  // 0 = read burst start, 1 = write burst start
    logic prev_oe, prev_rd, prev_wr;

    sync_fifo_master #(.DATA_W(DW), .BURST_LEN(BL)) u_sync_fifo_master (.*);

    always @(posedge clk) begin
        if (!rst_n) begin
            src_ptr <= 0; wr_cnt <= 0; tx_idx <= 0; rx_cnt <= 0;
            ovl_err <= 0; oe_err <= 0; rd_run <= 0; wr_run <= 0;
            max_rd_run <= 0; max_wr_run <= 0; ev_cnt <= 0;
            prev_oe <= 1'b1; prev_rd <= 1'b1; prev_wr <= 1'b1;
        end else begin
            if (!bus_rd_n && !bus_rx_avail_n) src_ptr <= src_ptr + 1;
            if (!bus_wr_n && !bus_tx_room_n) begin
                wr_log[wr_cnt] <= bus_dout;
                wr_be[wr_cnt]  <= bus_be_out;
                wr_fl[wr_cnt]  <= bus_flush_n;
                wr_cnt <= wr_cnt + 1;
            end
            if (tx_valid && tx_ready) tx_idx <= tx_idx + 1;
            if (rx_valid) begin
                rx_log[rx_cnt] <= rx_data;
                rx_cnt <= rx_cnt + 1;
            end
            if (!bus_rd_n && !bus_wr_n) ovl_err <= ovl_err + 1;
            if (prev_rd && !bus_rd_n && prev_oe) oe_err <= oe_err + 1;
            if (!prev_rd && bus_rd_n && bus_oe_n) oe_err <= oe_err + 1;
            if (bus_rd_n) rd_run <= 0;
            else if (!bus_rx_avail_n) begin
                rd_run <= rd_run + 1;
                if (rd_run + 1 > max_rd_run) max_rd_run <= rd_run + 1;
            end
            if (bus_wr_n) wr_run <= 0;
            else if (!bus_tx_room_n) begin
                wr_run <= wr_run + 1;
                if (wr_run + 1 > max_wr_run) max_wr_run <= wr_run + 1;
            end
            if (prev_oe && !bus_oe_n) begin ev[ev_cnt[5:0]] <= 1'b0; ev_cnt <= ev_cnt + 1; end
            if (prev_wr && !bus_wr_n) begin ev[ev_cnt[5:0]] <= 1'b1; ev_cnt <= ev_cnt + 1; end
            prev_oe <= bus_oe_n; prev_rd <= bus_rd_n; prev_wr <= bus_wr_n;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R1: quiet bus during reset.
    task automatic test_reset();
        src_len = 0; tx_len = 0; room_block = 1'b0; avail_block = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(bus_oe_n && bus_rd_n && bus_wr_n && bus_flush_n, "R1", "strobes in reset",
              {bus_oe_n, bus_rd_n, bus_wr_n, bus_flush_n}, 4'hF);
        check(!rx_valid && !tx_ready, "R1", "stream flags in reset", {rx_valid, tx_ready}, 0);
        rst_n = 1'b1;
    endtask

    // R2/R3: one packet with a partial final word, slave always has room.
    task automatic test_write_packet();
        int mis = 0;
        src_len = 0; tx_len = 3; last_keep = 4'b0011; room_block = 1'b0;
        for (int i = 0; i < 3; i++) tx_vec[i] = 32'hA5000000 + i;
        do_reset();
        idle_cycles(30);
        check(wr_cnt == 3, "R2", "packet word count", wr_cnt, 3);
        for (int i = 0; i < 3; i++) if (wr_log[i] != 32'hA5000000 + i) mis++;
        check(mis == 0, "R2", "packet word order mismatches", mis, 0);
        check(wr_fl[0] && wr_fl[1] && !wr_fl[2], "R3", "send-immediate placement",
              {wr_fl[0], wr_fl[1], wr_fl[2]}, 3'b110);
        check(wr_be[2] == 4'b0011 && wr_be[0] == 4'hF && wr_be[1] == 4'hF, "R3",
              "byte enables", {wr_be[0], wr_be[1], wr_be[2]}, 12'hFF3);
    endtask

    // R2/R8: room flag toggles mid-burst; refused words must be retried.
    task automatic test_write_stall();
        int mis = 0;
        src_len = 0; tx_len = 10; last_keep = 4'hF; room_block = 1'b1;
        for (int i = 0; i < 10; i++) tx_vec[i] = 32'h5C000100 + i * 3;
        do_reset();
        idle_cycles(6);
        check(wr_cnt == 0 && bus_wr_n, "R2", "no write while slave full", wr_cnt, 0);
        for (int c = 0; c < 60; c++) begin
            room_block = (c % 3 == 1);
            @(negedge clk);
        end
        room_block = 1'b0;
        idle_cycles(40);
        check(wr_cnt == 10, "R2", "stalled packet word count", wr_cnt, 10);
        for (int i = 0; i < 10; i++) if (wr_log[i] != 32'h5C000100 + i * 3) mis++;
        check(mis == 0, "R2", "stalled packet order mismatches", mis, 0);
        check(max_wr_run <= BL, "R8", "longest write burst", max_wr_run, BL);
    endtask

    // R4/R5/R8: plain read of six words: bursts of BL then remainder.
    task automatic test_read_plain();
        int mis = 0;
        tx_len = 0; src_len = 6; avail_block = 1'b0;
        for (int i = 0; i < 6; i++) src[i] = 32'h3E000000 + i * 17;
        do_reset();
        idle_cycles(30);
        check(rx_cnt == 6, "R5", "plain read count", rx_cnt, 6);
        for (int i = 0; i < 6; i++) if (rx_log[i] != 32'h3E000000 + i * 17) mis++;
        check(mis == 0, "R5", "plain read order mismatches", mis, 0);
        check(max_rd_run == BL, "R8", "full read burst length", max_rd_run, BL);
        check(oe_err == 0, "R4", "output enable framing errors", oe_err, 0);
    endtask

    // R5/R4: data flag pulses high; data on those edges must be dropped.
    task automatic test_read_gapped();
        int mis = 0;
        tx_len = 0; src_len = 9;
        for (int i = 0; i < 9; i++) src[i] = 32'hC0DE0000 + i;
        do_reset();
        for (int c = 0; c < 70; c++) begin
            avail_block = (c % 4 == 2);
            @(negedge clk);
        end
        avail_block = 1'b0;
        idle_cycles(20);
        check(rx_cnt == 9, "R5", "gapped read count", rx_cnt, 9);
        for (int i = 0; i < 9; i++) if (rx_log[i] != 32'hC0DE0000 + i) mis++;
        check(mis == 0, "R5", "gapped read order mismatches", mis, 0);
        check(oe_err == 0, "R4", "output enable framing errors", oe_err, 0);
    endtask

    // R7/R6: both directions pending from reset.
    task automatic test_alternate();
        int bad = 0;
        src_len = 12; tx_len = 12; last_keep = 4'hF;
        room_block = 1'b0; avail_block = 1'b0;
        for (int i = 0; i < 12; i++) begin
            src[i] = 32'h11110000 + i;
            tx_vec[i] = 32'h22220000 + i;
        end
        do_reset();
        idle_cycles(120);
        check(ev_cnt >= 6, "R7", "burst start count", ev_cnt, 6);
        for (int i = 0; i < 6; i++) if (ev[i] != (i % 2 == 1)) bad++;
        check(bad == 0, "R7", "read/write alternation mismatches", bad, 0);
        check(ovl_err == 0, "R6", "cycles with both strobes low", ovl_err, 0);
        check(rx_cnt == 12 && wr_cnt == 12, "R7", "both streams complete",
              {rx_cnt, wr_cnt}, {6'd12, 6'd12});
    endtask

    initial begin
        #(200000.0 * 5.0);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        test_write_packet();
        test_write_stall();
        test_read_plain();
        test_read_gapped();
        test_alternate();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule